// File: doc/BRIEF.md
# GMII Event-Message Timestamper

This block sits on the gigabit byte streams between a MAC and its PHY, on both the receive and the transmit side. On each path it watches for the start-of-frame delimiter. On the clock cycle in which that delimiter arrives, it latches the local slave time, held as 48-bit seconds and 32-bit nanoseconds. The block then follows the header bytes as they stream past. When the frame turns out to carry a precision-time event message, either directly over Ethernet or inside IPv4/UDP, the latched time is kept together with the message type and the sequence number. If the frame does not qualify, the capture is dropped. Because the time is taken at the byte interface next to the physical layer, the stamp carries almost none of the latency variation that builds up in higher layers.

Kept stamps go into a small first-in first-out queue for each direction, which a processor reads with a pop strobe. A queue that is already full drops the new stamp and raises a sticky overflow flag. Both byte streams are forwarded with one register stage and are not altered. A separate external trigger input is synchronised into the clock domain. On each rising edge of the trigger the block produces a timestamp, and this timestamp is corrected for the fixed delay of the synchroniser.

Top module: `ptp_gmii_stamper`

## Requirements
- R1: The receive and transmit valid, error and data inputs appear unchanged on the matching outputs one clock later.
- R2: A kept stamp holds the slave time present at the clock edge that samples byte 0xD5 with valid high. The byte must be the first 0xD5 since valid rose.
- R3: Bytes after the delimiter are numbered from 0. A frame is a direct event frame when bytes 12 and 13 hold 0x88 and 0xF7. Its message type is the low nibble of byte 14, and its sequence number is bytes 44 (high) and 45 (low).
- R4: A frame is a UDP event frame when it meets all of these: bytes 12 and 13 hold 0x08 and 0x00, byte 14 is 0x45, byte 23 is 17, and bytes 36 and 37 hold 0x01 and 0x3F (port 319). Its message type is the low nibble of byte 42, and its sequence number is bytes 72 (high) and 73 (low).
- R5: Only message types 0 to 3 are kept. Other types, other EtherTypes and other UDP ports leave the queue empty.
- R6: A frame produces no stamp if valid falls before its last sequence-number byte, or if the error input is high together with valid at any time after the delimiter.
- R7: Each direction queues up to QDEPTH (4) stamps in arrival order. The head entry and its valid flag are held until a pop.
- R8: A stamp that arrives while the queue is full and not being popped is dropped. The overflow flag for that direction then stays high until reset.
- R9: For each rising edge of the external trigger, ext_stb pulses for one cycle. The reported time is the slave time present at the first clock edge that sampled the trigger high, with a seconds borrow when needed.
- R10: After reset both queues are empty, both overflow flags are low and ext_stb is low.
- R11: The two directions are independent: traffic on one never adds an entry to, or sets the flag of, the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| now_sec | input | 48 | Slave time, seconds |
| now_ns | input | 32 | Slave time, nanoseconds |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| rxd | input | 8 | Receive data byte |
| rx_dv_o | output | 1 | Forwarded receive valid |
| rx_er_o | output | 1 | Forwarded receive error |
| rxd_o | output | 8 | Forwarded receive byte |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error |
| txd | input | 8 | Transmit data byte |
| tx_en_o | output | 1 | Forwarded transmit enable |
| tx_er_o | output | 1 | Forwarded transmit error |
| txd_o | output | 8 | Forwarded transmit byte |
| rx_pop | input | 1 | Remove head of receive queue |
| rx_ts_valid | output | 1 | Receive queue not empty |
| rx_ts_sec | output | 48 | Head stamp seconds |
| rx_ts_ns | output | 32 | Head stamp nanoseconds |
| rx_ts_mtype | output | 4 | Head message type |
| rx_ts_seq | output | 16 | Head sequence number |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_pop | input | 1 | Remove head of transmit queue |
| tx_ts_valid | output | 1 | Transmit queue not empty |
| tx_ts_sec | output | 48 | Head stamp seconds |
| tx_ts_ns | output | 32 | Head stamp nanoseconds |
| tx_ts_mtype | output | 4 | Head message type |
| tx_ts_seq | output | 16 | Head sequence number |
| tx_ovf | output | 1 | Sticky transmit overflow |
| ext_trig | input | 1 | Asynchronous capture trigger |
| ext_stb | output | 1 | External stamp strobe |
| ext_sec | output | 48 | External stamp seconds |
| ext_ns | output | 32 | External stamp nanoseconds |

## Verification
The hardest case to reach is an external trigger whose corrected stamp has to borrow from the seconds field. The subtraction must cross a nanosecond rollover that took place inside the synchroniser window. The bench loads the slave time to 8 ns below a second boundary on the same cycle in which it raises the trigger, so the raw time captured two cycles later has already wrapped. The other case that takes deliberate work is a full queue, together with a sweep of every message type over both encapsulations and both directions. For these, the bench streams complete frames without popping and compares each head field with the time it recorded at the delimiter.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

  localparam logic [7:0]  SFD_BYTE     = 8'hD5;
  localparam logic [15:0] ETYPE_PTP    = 16'h88F7;
  localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
  localparam logic [7:0]  IPV4_VERIHL  = 8'h45;
  localparam logic [7:0]  IP_PROTO_UDP = 8'd17;
  localparam logic [15:0] UDP_EVT_PORT = 16'd319;
  localparam logic [31:0] NS_PER_SEC   = 32'd1_000_000_000;

  // Byte offsets counted from the first byte after the delimiter.
  localparam int unsigned OFS_W = 7;
  localparam logic [OFS_W-1:0] OFS_ET_HI    = 7'd12;
  localparam logic [OFS_W-1:0] OFS_ET_LO    = 7'd13;
  localparam logic [OFS_W-1:0] OFS_L3_FIRST = 7'd14;
  localparam logic [OFS_W-1:0] OFS_IP_PROTO = 7'd23;
  localparam logic [OFS_W-1:0] OFS_DPORT_HI = 7'd36;
  localparam logic [OFS_W-1:0] OFS_DPORT_LO = 7'd37;
  localparam logic [OFS_W-1:0] OFS_U_MTYPE  = 7'd42;
  localparam logic [OFS_W-1:0] OFS_L_SEQ_HI = 7'd44;
  localparam logic [OFS_W-1:0] OFS_L_SEQ_LO = 7'd45;
  localparam logic [OFS_W-1:0] OFS_U_SEQ_HI = 7'd72;
  localparam logic [OFS_W-1:0] OFS_U_SEQ_LO = 7'd73;

  typedef struct packed {
    logic [47:0] sec;
    logic [31:0] ns;
    logic [3:0]  mtype;
    logic [15:0] seq;
  } ts_entry_t;

endpackage

// File: rtl/ptp_frame_parser.sv
module ptp_frame_parser
  import ptp_stamp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        dv,
  input  logic        er,
  input  logic [7:0]  d,
  input  logic [47:0] now_sec,
  input  logic [31:0] now_ns,
  output logic        push,
  output ts_entry_t   entry
);

  localparam logic [OFS_W-1:0] CNT_MAX = '1;

  logic             active;
  logic [OFS_W-1:0] cnt;
  logic [7:0]       et_hi;
  logic             is_l2;
  logic             is_ip;
  logic             bad;
  logic             got_all;
  logic [3:0]       mtype;
  logic [15:0]      seq;
  logic [47:0]      cap_sec;
  logic [31:0]      cap_ns;
  logic             field_fail;

  // A header byte that contradicts the expected encapsulation.
  always_comb begin
    field_fail = 1'b0;
    case (cnt)
      OFS_ET_LO:    field_fail = !(({et_hi, d} == ETYPE_PTP) || ({et_hi, d} == ETYPE_IPV4));
      OFS_L3_FIRST: field_fail = is_ip && (d != IPV4_VERIHL);
      OFS_IP_PROTO: field_fail = is_ip && (d != IP_PROTO_UDP);
      OFS_DPORT_HI: field_fail = is_ip && (d != UDP_EVT_PORT[15:8]);
      OFS_DPORT_LO: field_fail = is_ip && (d != UDP_EVT_PORT[7:0]);
      default:      field_fail = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      et_hi   <= '0;
      is_l2   <= 1'b0;
      is_ip   <= 1'b0;
      bad     <= 1'b0;
      got_all <= 1'b0;
      mtype   <= '1;
      seq     <= '0;
      cap_sec <= '0;
      cap_ns  <= '0;
    end else if (!dv) begin
      active <= 1'b0;
    end else if (!active) begin
      if (d == SFD_BYTE) begin
        // Speculative capture; kept only if the header qualifies.
        active  <= 1'b1;
        cnt     <= '0;
        cap_sec <= now_sec;
        cap_ns  <= now_ns;
        bad     <= er;
        is_l2   <= 1'b0;
        is_ip   <= 1'b0;
        got_all <= 1'b0;
        mtype   <= '1;
        seq     <= '0;
      end
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (er || field_fail) bad <= 1'b1;
      case (cnt)
        OFS_ET_HI: et_hi <= d;
        OFS_ET_LO: begin
          is_l2 <= ({et_hi, d} == ETYPE_PTP);
          is_ip <= ({et_hi, d} == ETYPE_IPV4);
        end
        OFS_L3_FIRST: if (is_l2) mtype <= d[3:0];
        OFS_U_MTYPE:  if (is_ip) mtype <= d[3:0];
        OFS_L_SEQ_HI: if (is_l2) seq[15:8] <= d;
        OFS_L_SEQ_LO: if (is_l2) begin
          seq[7:0] <= d;
          got_all  <= 1'b1;
        end
        OFS_U_SEQ_HI: if (is_ip) seq[15:8] <= d;
        OFS_U_SEQ_LO: if (is_ip) begin
          seq[7:0] <= d;
          got_all  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Commit at end of frame: complete, error-free, event message type.
  assign push  = active && !dv && !bad && got_all && (mtype[3:2] == 2'b00);
  assign entry = '{sec: cap_sec, ns: cap_ns, mtype: mtype, seq: seq};

endmodule

// File: rtl/ptp_stamp_fifo.sv
module ptp_stamp_fifo #(
  parameter int unsigned WIDTH = 100,
  parameter int unsigned DEPTH = 4   // power of two
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic             valid,
  output logic [WIDTH-1:0] dout,
  output logic             ovf
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [AW:0]      count;
  logic             pop_eff;
  logic             accept;

  assign pop_eff = pop && (count != '0);
  assign accept  = push && ((count != FULL_CNT) || pop_eff);

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (accept)  wr_ptr <= wr_ptr + 1'b1;
      if (pop_eff) rd_ptr <= rd_ptr + 1'b1;
      case ({accept, pop_eff})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !accept) ovf <= 1'b1;
    end
  end

  assign valid = (count != '0);
  assign dout  = mem[rd_ptr];

endmodule

// File: rtl/ptp_ext_capture.sv
module ptp_ext_capture
  import ptp_stamp_pkg::*;
#(
  parameter int unsigned CLK_NS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trig,
  input  logic [47:0] now_sec,
  input  logic [31:0] now_ns,
  output logic        stb,
  output logic [47:0] sec,
  output logic [31:0] ns
);

  // Clock edges between first sample of the trigger and the capture edge.
  localparam logic [31:0] LAT_NS = 32'(SYNC_STAGES * CLK_NS);

  logic [SYNC_STAGES:0] sync_q;
  logic                 rise;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], trig};
  end

  assign rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      stb <= 1'b0;
      sec <= '0;
      ns  <= '0;
    end else begin
      stb <= rise;
      if (rise) begin
        if (now_ns >= LAT_NS) begin
          sec <= now_sec;
          ns  <= now_ns - LAT_NS;
        end else begin
          sec <= now_sec - 48'd1;
          ns  <= now_ns + NS_PER_SEC - LAT_NS;
        end
      end
    end
  end

endmodule

// File: rtl/ptp_gmii_stamper.sv
module ptp_gmii_stamper
  import ptp_stamp_pkg::*;
#(
  parameter int unsigned QDEPTH      = 4,
  parameter int unsigned CLK_NS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [47:0] now_sec,
  input  logic [31:0] now_ns,
  input  logic        rx_dv,
  input  logic        rx_er,
  input  logic [7:0]  rxd,
  output logic        rx_dv_o,
  output logic        rx_er_o,
  output logic [7:0]  rxd_o,
  input  logic        tx_en,
  input  logic        tx_er,
  input  logic [7:0]  txd,
  output logic        tx_en_o,
  output logic        tx_er_o,
  output logic [7:0]  txd_o,
  input  logic        rx_pop,
  output logic        rx_ts_valid,
  output logic [47:0] rx_ts_sec,
  output logic [31:0] rx_ts_ns,
  output logic [3:0]  rx_ts_mtype,
  output logic [15:0] rx_ts_seq,
  output logic        rx_ovf,
  input  logic        tx_pop,
  output logic        tx_ts_valid,
  output logic [47:0] tx_ts_sec,
  output logic [31:0] tx_ts_ns,
  output logic [3:0]  tx_ts_mtype,
  output logic [15:0] tx_ts_seq,
  output logic        tx_ovf,
  input  logic        ext_trig,
  output logic        ext_stb,
  output logic [47:0] ext_sec,
  output logic [31:0] ext_ns
);

  localparam int unsigned NDIR    = 2;   // 0 = receive, 1 = transmit
  localparam int unsigned ENTRY_W = $bits(ts_entry_t);

  logic      dv_a   [NDIR];
  logic      er_a   [NDIR];
  logic [7:0] d_a   [NDIR];
  logic      pop_a  [NDIR];
  logic      vld_a  [NDIR];
  logic      ovf_a  [NDIR];
  ts_entry_t head_a [NDIR];
  logic      dvq_a  [NDIR];
  logic      erq_a  [NDIR];
  logic [7:0] dq_a  [NDIR];

  assign dv_a[0]  = rx_dv;
  assign er_a[0]  = rx_er;
  assign d_a[0]   = rxd;
  assign pop_a[0] = rx_pop;
  assign dv_a[1]  = tx_en;
  assign er_a[1]  = tx_er;
  assign d_a[1]   = txd;
  assign pop_a[1] = tx_pop;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    logic      push;
    ts_entry_t entry;
    logic [ENTRY_W-1:0] head_bits;

    // Byte stream forwarded through one register stage.
    always_ff @(posedge clk) begin
      if (rst) begin
        dvq_a[g] <= 1'b0;
        erq_a[g] <= 1'b0;
        dq_a[g]  <= '0;
      end else begin
        dvq_a[g] <= dv_a[g];
        erq_a[g] <= er_a[g];
        dq_a[g]  <= d_a[g];
      end
    end

    ptp_frame_parser u_parser (
      .clk     (clk),
      .rst     (rst),
      .dv      (dv_a[g]),
      .er      (er_a[g]),
      .d       (d_a[g]),
      .now_sec (now_sec),
      .now_ns  (now_ns),
      .push    (push),
      .entry   (entry)
    );

    ptp_stamp_fifo #(
      .WIDTH (ENTRY_W),
      .DEPTH (QDEPTH)
    ) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push),
      .din   (entry),
      .pop   (pop_a[g]),
      .valid (vld_a[g]),
      .dout  (head_bits),
      .ovf   (ovf_a[g])
    );

    assign head_a[g] = ts_entry_t'(head_bits);
  end

  assign rx_dv_o     = dvq_a[0];
  assign rx_er_o     = erq_a[0];
  assign rxd_o       = dq_a[0];
  assign tx_en_o     = dvq_a[1];
  assign tx_er_o     = erq_a[1];
  assign txd_o       = dq_a[1];

  assign rx_ts_valid = vld_a[0];
  assign rx_ts_sec   = head_a[0].sec;
  assign rx_ts_ns    = head_a[0].ns;
  assign rx_ts_mtype = head_a[0].mtype;
  assign rx_ts_seq   = head_a[0].seq;
  assign rx_ovf      = ovf_a[0];

  assign tx_ts_valid = vld_a[1];
  assign tx_ts_sec   = head_a[1].sec;
  assign tx_ts_ns    = head_a[1].ns;
  assign tx_ts_mtype = head_a[1].mtype;
  assign tx_ts_seq   = head_a[1].seq;
  assign tx_ovf      = ovf_a[1];

  ptp_ext_capture #(
    .CLK_NS      (CLK_NS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ext (
    .clk     (clk),
    .rst     (rst),
    .trig    (ext_trig),
    .now_sec (now_sec),
    .now_ns  (now_ns),
    .stb     (ext_stb),
    .sec     (ext_sec),
    .ns      (ext_ns)
  );

endmodule

// File: rtl/ptp_gmii_stamper_chk.sv
module ptp_gmii_stamper_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_dv,
  input logic [7:0]  rxd,
  input logic        rx_dv_o,
  input logic [7:0]  rxd_o,
  input logic        rx_pop,
  input logic        rx_ts_valid,
  input logic [3:0]  rx_ts_mtype,
  input logic [15:0] rx_ts_seq,
  input logic        rx_ovf,
  input logic        tx_ts_valid,
  input logic [3:0]  tx_ts_mtype,
  input logic        tx_ovf,
  input logic        ext_stb,
  input logic [31:0] ext_ns
);

  AST_RX_FORWARD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (rx_dv_o == $past(rx_dv)) && (rxd_o == $past(rxd))); // R1

  AST_RX_EVENT_TYPE: assert property (@(posedge clk) disable iff (rst)
    rx_ts_valid |-> (rx_ts_mtype < 4'd4)); // R5

  AST_TX_EVENT_TYPE: assert property (@(posedge clk) disable iff (rst)
    tx_ts_valid |-> (tx_ts_mtype < 4'd4)); // R5

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
    (rx_ts_valid && !rx_pop) |=> (rx_ts_valid && $stable(rx_ts_seq))); // R7

  AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(rx_ovf) |-> rx_ovf); // R8

  AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(tx_ovf) |-> tx_ovf); // R8

  AST_EXT_PULSE: assert property (@(posedge clk) disable iff (rst)
    ext_stb |=> !ext_stb); // R9

  AST_EXT_NS_RANGE: assert property (@(posedge clk) disable iff (rst)
    ext_stb |-> (ext_ns < 32'd1_000_000_000)); // R9

endmodule

bind ptp_gmii_stamper ptp_gmii_stamper_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_dv       (rx_dv),
  .rxd         (rxd),
  .rx_dv_o     (rx_dv_o),
  .rxd_o       (rxd_o),
  .rx_pop      (rx_pop),
  .rx_ts_valid (rx_ts_valid),
  .rx_ts_mtype (rx_ts_mtype),
  .rx_ts_seq   (rx_ts_seq),
  .rx_ovf      (rx_ovf),
  .tx_ts_valid (tx_ts_valid),
  .tx_ts_mtype (tx_ts_mtype),
  .tx_ovf      (tx_ovf),
  .ext_stb     (ext_stb),
  .ext_ns      (ext_ns)
);

// File: tb/ptp_gmii_stamper_bench.sv
`timescale 1ns/1ps
module ptp_gmii_stamper_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] now_sec;
  logic [31:0] now_ns;
  logic        rx_dv = 0, rx_er = 0, tx_en = 0, tx_er = 0;
  logic [7:0]  rxd = 0, txd = 0;
  logic        rx_dv_o, rx_er_o, tx_en_o, tx_er_o;
  logic [7:0]  rxd_o, txd_o;
  logic        rx_pop = 0, tx_pop = 0;
  logic        rx_ts_valid, tx_ts_valid, rx_ovf, tx_ovf;
  logic [47:0] rx_ts_sec, tx_ts_sec, ext_sec;
  logic [31:0] rx_ts_ns, tx_ts_ns, ext_ns;
  logic [3:0]  rx_ts_mtype, tx_ts_mtype;
  logic [15:0] rx_ts_seq, tx_ts_seq;
  logic        ext_trig = 0, ext_stb;

  logic        set_req = 0;
  logic [47:0] set_sec = 0;
  logic [31:0] set_ns = 0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_on = 0;

  always #4 clk = ~clk;   // 125 MHz

  // Slave time model: 8 ns per clock, loadable.
  always @(posedge clk) begin
    if (rst) begin
      now_sec <= 48'h0000_0000_1234;
      now_ns  <= 32'd0;
    end else if (set_req) begin
      now_sec <= set_sec;
      now_ns  <= set_ns;
    end else if (now_ns + 32'd8 >= 32'd1_000_000_000) begin
      now_sec <= now_sec + 48'd1;
      now_ns  <= now_ns + 32'd8 - 32'd1_000_000_000;
    end else begin
      now_ns  <= now_ns + 32'd8;
    end
  end

  ptp_gmii_stamper u_ptp_gmii_stamper (
    .clk(clk), .rst(rst), .now_sec(now_sec), .now_ns(now_ns),
    .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
    .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o), .rxd_o(rxd_o),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .tx_en_o(tx_en_o), .tx_er_o(tx_er_o), .txd_o(txd_o),
    .rx_pop(rx_pop), .rx_ts_valid(rx_ts_valid), .rx_ts_sec(rx_ts_sec),
    .rx_ts_ns(rx_ts_ns), .rx_ts_mtype(rx_ts_mtype), .rx_ts_seq(rx_ts_seq),
    .rx_ovf(rx_ovf),
    .tx_pop(tx_pop), .tx_ts_valid(tx_ts_valid), .tx_ts_sec(tx_ts_sec),
    .tx_ts_ns(tx_ts_ns), .tx_ts_mtype(tx_ts_mtype), .tx_ts_seq(tx_ts_seq),
    .tx_ovf(tx_ovf),
    .ext_trig(ext_trig), .ext_stb(ext_stb), .ext_sec(ext_sec), .ext_ns(ext_ns)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // R1 forwarding monitor
  logic       p_rdv, p_rer, p_ten, p_ter;
  logic [7:0] p_rd, p_td;
  always @(posedge clk) begin
    p_rdv <= rx_dv; p_rer <= rx_er; p_rd <= rxd;
    p_ten <= tx_en; p_ter <= tx_er; p_td <= txd;
  end
  always @(negedge clk) begin
    if (mon_on) begin
      chk({rx_dv_o, rx_er_o, rxd_o} == {p_rdv, p_rer, p_rd}, "R1 rx forward",
          {rx_dv_o, rx_er_o, rxd_o}, {p_rdv, p_rer, p_rd});
      chk({tx_en_o, tx_er_o, txd_o} == {p_ten, p_ter, p_td}, "R1 tx forward",
          {tx_en_o, tx_er_o, txd_o}, {p_ten, p_ter, p_td});
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // kind: 0 direct event, 1 UDP event, 2 other EtherType, 3 UDP wrong port
  function automatic logic [7:0] fbyte(int kind, int idx, int mt, int sq);
    logic [7:0] b;
    b = 8'(idx) ^ 8'h5A;
    if (idx == 12) b = (kind == 0) ? 8'h88 : 8'h08;
    if (idx == 13) b = (kind == 0) ? 8'hF7 : (kind == 2) ? 8'h06 : 8'h00;
    if (kind == 0) begin
      if (idx == 14) b = {4'h1, 4'(mt)};
      if (idx == 44) b = 8'(sq >> 8);
      if (idx == 45) b = 8'(sq);
    end else if (kind != 2) begin
      if (idx == 14) b = 8'h45;
      if (idx == 23) b = 8'd17;
      if (idx == 36) b = 8'h01;
      if (idx == 37) b = (kind == 3) ? 8'h40 : 8'h3F;
      if (idx == 42) b = {4'h2, 4'(mt)};
      if (idx == 72) b = 8'(sq >> 8);
      if (idx == 73) b = 8'(sq);
    end
    return b;
  endfunction

  task automatic drive(input int dir, input logic v, input logic e, input logic [7:0] b);
    if (dir == 0) begin rx_dv = v; rx_er = e; rxd = b; end
    else          begin tx_en = v; tx_er = e; txd = b; end
  endtask

  // Sends one frame; returns time presented at the delimiter edge.
  task automatic send(input int dir, input int kind, input int mt, input int sq,
                      input int cut_at, input int err_at,
                      output logic [47:0] s_sec, output logic [31:0] s_ns);
    int len;
    len = (kind == 1 || kind == 3) ? 80 : 60;
    if (cut_at >= 0) len = cut_at;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); drive(dir, 1'b1, 1'b0, 8'h55);
    end
    @(negedge clk); drive(dir, 1'b1, 1'b0, 8'hD5);
    s_sec = now_sec; s_ns = now_ns;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); drive(dir, 1'b1, (i == err_at), fbyte(kind, i, mt, sq));
    end
    @(negedge clk); drive(dir, 1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_one(input int dir);
    if (dir == 0) rx_pop = 1; else tx_pop = 1;
    @(negedge clk);
    rx_pop = 0; tx_pop = 0;
  endtask

  task automatic check_head(input int dir, input string tag, input logic [47:0] es,
                            input logic [31:0] en, input int mt, input int sq);
    if (dir == 0) begin
      chk(rx_ts_valid, {tag, " rx valid"}, rx_ts_valid, 1);
      chk(rx_ts_sec == es, {tag, " rx sec"}, rx_ts_sec, es);
      chk(rx_ts_ns == en, {tag, " rx ns"}, rx_ts_ns, en);
      chk(rx_ts_mtype == 4'(mt), {tag, " rx mtype"}, rx_ts_mtype, mt);
      chk(rx_ts_seq == 16'(sq), {tag, " rx seq"}, rx_ts_seq, sq);
    end else begin
      chk(tx_ts_valid, {tag, " tx valid"}, tx_ts_valid, 1);
      chk(tx_ts_sec == es, {tag, " tx sec"}, tx_ts_sec, es);
      chk(tx_ts_ns == en, {tag, " tx ns"}, tx_ts_ns, en);
      chk(tx_ts_mtype == 4'(mt), {tag, " tx mtype"}, tx_ts_mtype, mt);
      chk(tx_ts_seq == 16'(sq), {tag, " tx seq"}, tx_ts_seq, sq);
    end
  endtask

  task automatic check_empty(input string tag);
    chk(!rx_ts_valid, {tag, " rx empty"}, rx_ts_valid, 0);
    chk(!tx_ts_valid, {tag, " tx empty"}, tx_ts_valid, 0);
  endtask

  task automatic ext_shot(input string tag, input logic [47:0] es, input logic [31:0] en);
    bit seen;
    ext_trig = 1;
    seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk);
      if (ext_stb) begin
        seen = 1;
        chk(ext_sec == es, {tag, " ext sec"}, ext_sec, es);
        chk(ext_ns == en, {tag, " ext ns"}, ext_ns, en);
        @(negedge clk);
        chk(!ext_stb, {tag, " ext pulse width"}, ext_stb, 0);
      end
    end
    chk(seen, {tag, " ext strobe seen"}, seen, 1);
    ext_trig = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [47:0] ss;
    logic [31:0] sn;
    logic [47:0] qs [4];
    logic [31:0] qn [4];

    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(!rx_ts_valid && !tx_ts_valid, "R10 queues empty", {rx_ts_valid, tx_ts_valid}, 0);
    chk(!rx_ovf && !tx_ovf, "R10 overflow clear", {rx_ovf, tx_ovf}, 0);
    chk(!ext_stb, "R10 ext strobe low", ext_stb, 0);
    @(negedge clk);
    mon_on = 1;

    // R2 R3 R4 R5 R11: sweep both directions, both encapsulations, every type
    for (int dir = 0; dir < 2; dir++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int mt = 0; mt < 16; mt++) begin
          int sq;
          sq = (dir << 12) | (kind << 8) | (mt * 17) | 16'hA000;
          send(dir, kind, mt, sq, -1, -1, ss, sn);
          if (mt < 4) begin
            check_head(dir, (kind == 0) ? "R2 R3 event" : "R2 R4 event", ss, sn, mt, sq);
            if (dir == 0) chk(!tx_ts_valid, "R11 tx untouched", tx_ts_valid, 0);
            else          chk(!rx_ts_valid, "R11 rx untouched", rx_ts_valid, 0);
            pop_one(dir);
          end
          check_empty("R5 type filter");
        end
      end
    end

    // R5 other EtherType and wrong UDP port
    send(0, 2, 0, 16'h1111, -1, -1, ss, sn);
    check_empty("R5 other ethertype");
    send(1, 3, 1, 16'h2222, -1, -1, ss, sn);
    check_empty("R5 wrong udp port");

    // R6 early end and error
    send(0, 0, 0, 16'h3333, 45, -1, ss, sn);
    check_empty("R6 cut before seq lo");
    send(1, 1, 2, 16'h4444, 60, -1, ss, sn);
    check_empty("R6 udp cut early");
    send(0, 0, 1, 16'h5555, -1, 20, ss, sn);
    check_empty("R6 rx error");
    send(1, 1, 3, 16'h6666, -1, 75, ss, sn);
    check_empty("R6 tx error after seq");

    // R7 R8 fill receive queue, then overflow
    for (int k = 0; k < 4; k++) begin
      send(0, 0, k, 16'h7000 + k, -1, -1, ss, sn);
      qs[k] = ss; qn[k] = sn;
    end
    chk(!rx_ovf, "R8 no overflow at full", rx_ovf, 0);
    send(0, 0, 0, 16'h70FF, -1, -1, ss, sn);
    chk(rx_ovf, "R8 overflow set", rx_ovf, 1);
    chk(!tx_ovf, "R11 tx overflow clear", tx_ovf, 0);
    for (int k = 0; k < 4; k++) begin
      check_head(0, "R7 order", qs[k], qn[k], k, 16'h7000 + k);
      pop_one(0);
    end
    check_empty("R8 newest dropped");
    chk(rx_ovf, "R8 overflow sticky", rx_ovf, 1);

    // R9 external trigger, plain and with seconds borrow
    @(negedge clk);
    ext_shot("R9 plain", now_sec, now_ns);
    set_sec = 48'h0000_0000_ABCD;
    set_ns  = 32'd999_999_992;
    set_req = 1;
    @(negedge clk);
    set_req = 0;
    ext_shot("R9 borrow", 48'h0000_0000_ABCD, 32'd999_999_992);
    set_ns  = 32'd16;
    set_req = 1;
    @(negedge clk);
    set_req = 0;
    ext_shot("R9 exact latency", 48'h0000_0000_ABCD, 32'd16);

    mon_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule